// File: doc/BRIEF.md
# Threshold-Triggered Write FIFO Controller

This block is the transmit-side word buffer of a memory-card style host interface. The CPU pushes words in, and the card-side engine pulls them out. The block decides when an outgoing block write may begin on the card bus. It compares the FIFO occupancy against a threshold that depends on the programmed block length, or it starts at once when the immediate mode is selected. Once `start_o` is raised, it stays up until the card side has taken the whole block.

A two-bit configuration register selects the start mode and the clearing policy of the flow-error flags. A separate protect input blocks writes to this register. An overflow is a CPU push into a full FIFO. An underflow is a card-side pull from an empty FIFO while a transfer is armed. Each raises a sticky flag. Depending on the policy bit, the flags are cleared either by the next transfer command or by a status read.

Top module: `tx_fifo_gate`

## Requirements
- R1: After reset the configuration reads 0, `level_o` is 0, `empty_o` is 1, `full_o` is 0, and `start_o`, `ovf_o` and `udf_o` are 0.
- R2: A `cfg_we_i` pulse loads `cfg_wdata_i` into the configuration (bit 0 = immediate start, bit 1 = status-read clearing) only while `wp_en_i` is 0. With `wp_en_i` at 1 the write is ignored. `cfg_o` shows the register.
- R3: Words leave in the order they entered. `level_o` counts stored words, with `full_o` at DEPTH and `empty_o` at 0. An accepted push and pop in the same cycle leave `level_o` unchanged.
- R4: With bit 0 clear and 4*len >= 3*DEPTH, `start_o` rises once `level_o` >= DEPTH/2.
- R5: With bit 0 clear and 2*len >= DEPTH > 4*len/3, `start_o` rises once `level_o` >= DEPTH/4.
- R6: With bit 0 clear and 2*len < DEPTH, `start_o` rises only once `level_o` >= len.
- R7: With bit 0 set, `start_o` rises once `level_o` >= 1.
- R8: `cmd_start_i` latches `blk_len_i` (nonzero) and arms a transfer. `start_o` is registered and rises on the clock edge after the edge at which the level first meets the threshold. It stays high until len words have been popped, and it falls at the edge of the last pop.
- R9: A push while `full_o` is 1 sets `ovf_o` and discards the word, even if a pop happens in the same cycle.
- R10: A pop while `empty_o` is 1 and a transfer is armed sets `udf_o`. A pop on an empty FIFO with no armed transfer changes no flag.
- R11: With bit 1 clear, `cmd_start_i` clears both flags and `stat_rd_i` has no effect. With bit 1 set, `stat_rd_i` clears them and `cmd_start_i` does not.
- R12: An error event in the same cycle as a clearing strobe leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 2 | Configuration write data |
| wp_en_i | input | 1 | Configuration write protect |
| cfg_o | output | 2 | Configuration register contents |
| push_i | input | 1 | CPU word push |
| push_data_i | input | DW | CPU word |
| pop_i | input | 1 | Card-side word pull |
| pop_data_o | output | DW | Head word (show-ahead) |
| blk_len_i | input | LW | Block length in words |
| cmd_start_i | input | 1 | New transfer command |
| stat_rd_i | input | 1 | Status read strobe |
| start_o | output | 1 | Block write may proceed |
| level_o | output | CW | Stored word count |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| ovf_o | output | 1 | Overflow flag |
| udf_o | output | 1 | Underflow flag |

## Verification
The bench builds the block with DEPTH=16, DW=16 and LW=8. With these values each threshold band can be reached with a short block. Length 3 falls in the whole-block band, length 8 in the quarter band (threshold 4), and length 12 sits exactly on the half-band boundary (threshold 8). Sixteen pushes are enough to fill the FIFO, so overflow and word discard can be exercised, and the same short transfers exercise underflow and both clearing policies.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  typedef struct packed {
    logic stat_clr;   // flags cleared by status read instead of command
    logic imm_start;  // start on first stored word
  } tx_cfg_t;
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] FullCnt = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  assign full_o    = (cnt_q == FullCnt);
  assign empty_o   = (cnt_q == '0);
  assign push_ok_o = push_i && !full_o;
  assign pop_ok_o  = pop_i && !empty_o;
  assign level_o   = cnt_q;
  assign pop_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok_o)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_level_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FullCnt);
  p_same_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok_o && pop_ok_o) |=> $stable(cnt_q));
  p_full_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({full_o, empty_o}));
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = 8,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          imm_i,
  input  logic          cmd_i,
  input  logic [LW-1:0] len_i,
  input  logic [CW-1:0] level_i,
  input  logic          pop_ok_i,
  output logic          active_o,
  output logic          start_o
);
  localparam int unsigned Q3Depth   = 3 * DEPTH;
  localparam int unsigned HalfDepth = DEPTH / 2;
  localparam int unsigned QtrDepth  = DEPTH / 4;

  logic [LW-1:0] len_q, rem_q;
  logic          active_q, start_q;
  int unsigned   len_u, thr;
  logic          cond;

  always_comb begin
    len_u = 32'(len_q);
    if (imm_i)                    thr = 1;
    else if (len_u * 4 >= Q3Depth) thr = HalfDepth;
    else if (len_u * 2 >= DEPTH)  thr = QtrDepth;
    else                          thr = len_u;
    cond = (32'(level_i) >= thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      rem_q    <= '0;
      active_q <= 1'b0;
      start_q  <= 1'b0;
    end else if (cmd_i) begin
      len_q    <= len_i;
      rem_q    <= len_i;
      active_q <= 1'b1;
      start_q  <= 1'b0;
    end else if (active_q) begin
      if (!start_q && cond) start_q <= 1'b1;
      if (start_q && pop_ok_i) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == LW'(1)) begin
          start_q  <= 1'b0;
          active_q <= 1'b0;
        end
      end
    end
  end

  assign active_o = active_q;
  assign start_o  = start_q;

  p_start_has_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(level_i) != '0);
  p_start_needs_arm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> active_o);
  p_start_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_o) |-> ($past(pop_ok_i) || $past(cmd_i)));
endmodule

// File: rtl/tx_flow_flags.sv
module tx_flow_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_evt_i,
  input  logic udf_evt_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic udf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      // new event outranks a clear in the same cycle
      ovf_o <= ovf_evt_i || (ovf_o && !clr_i);
      udf_o <= udf_evt_i || (udf_o && !clr_i);
    end
  end

  p_ovf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_o);
  p_udf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_evt_i |=> udf_o);
  p_flag_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
  p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (ovf_evt_i || udf_evt_i)) |=> (ovf_o || udf_o));
endmodule

// File: rtl/tx_fifo_gate.sv
module tx_fifo_gate
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,  // power of two, multiple of four
  parameter int unsigned DW    = 32,
  parameter int unsigned LW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_wdata_i,
  input  logic          wp_en_i,
  output logic [1:0]    cfg_o,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  input  logic [LW-1:0] blk_len_i,
  input  logic          cmd_start_i,
  input  logic          stat_rd_i,
  output logic          start_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          udf_o
);
  tx_cfg_t cfg_q;
  logic    push_ok, pop_ok, active, flag_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cfg_q <= '0;
    else if (cfg_we_i && !wp_en_i)   cfg_q <= tx_cfg_t'(cfg_wdata_i);
  end
  assign cfg_o = cfg_q;

  tx_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni, .push_i, .push_data_i, .pop_i, .pop_data_o,
    .push_ok_o(push_ok), .pop_ok_o(pop_ok), .level_o, .full_o, .empty_o
  );

  tx_start_gate #(.DEPTH(DEPTH), .LW(LW), .CW(CW)) u_gate (
    .clk_i, .rst_ni, .imm_i(cfg_q.imm_start), .cmd_i(cmd_start_i),
    .len_i(blk_len_i), .level_i(level_o), .pop_ok_i(pop_ok),
    .active_o(active), .start_o
  );

  assign flag_clr = cfg_q.stat_clr ? stat_rd_i : cmd_start_i;

  tx_flow_flags u_flags (
    .clk_i, .rst_ni,
    .ovf_evt_i(push_i && full_o),
    .udf_evt_i(pop_i && empty_o && active),
    .clr_i(flag_clr), .ovf_o, .udf_o
  );

  p_cfg_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wp_en_i) |=> $stable(cfg_o));
  p_no_push_when_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(level_o));
endmodule

// File: tb/tx_fifo_gate_tb.sv
module tx_fifo_gate_tb;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned DW    = 16;
  localparam int unsigned LW    = 8;
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam time CLK_PERIOD    = 10ns;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          cfg_we_i = 0, wp_en_i = 0, push_i = 0, pop_i = 0;
  logic          cmd_start_i = 0, stat_rd_i = 0;
  logic [1:0]    cfg_wdata_i = '0, cfg_o;
  logic [DW-1:0] push_data_i = '0, pop_data_o;
  logic [LW-1:0] blk_len_i = '0;
  logic          start_o, full_o, empty_o, ovf_o, udf_o;
  logic [CW-1:0] level_o;

  int checks = 0, errors = 0;
  int mcnt = 0;
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] seed = 16'h1000;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tx_fifo_gate #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_w();
    seed = seed + 16'h0101;
    push_i = 1; push_data_i = seed;
    if (mcnt < DEPTH) begin exp_q.push_back(seed); mcnt++; end
    @(negedge clk_i); push_i = 0;
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) push_w();
  endtask

  // monitor side of scoreboard: head word compared before it is taken
  task automatic pop_w();
    logic [DW-1:0] e;
    if (exp_q.size() == 0) begin
      chk("R3 scoreboard empty", 1, 0);
    end else begin
      e = exp_q.pop_front(); mcnt--;
      chk("R3 order", 32'(pop_data_o), 32'(e));
    end
    pop_i = 1; @(negedge clk_i); pop_i = 0;
  endtask

  task automatic pop_n(int n);
    for (int i = 0; i < n; i++) pop_w();
  endtask

  task automatic raw_pop(bit with_stat);
    pop_i = 1; stat_rd_i = with_stat; @(negedge clk_i); pop_i = 0; stat_rd_i = 0;
  endtask

  task automatic cmd(int len);
    blk_len_i = LW'(len); cmd_start_i = 1; @(negedge clk_i); cmd_start_i = 0;
  endtask

  task automatic cfg_wr(logic [1:0] v, logic wp);
    cfg_wdata_i = v; wp_en_i = wp; cfg_we_i = 1; @(negedge clk_i);
    cfg_we_i = 0; wp_en_i = 0;
  endtask

  task automatic stat_rd();
    stat_rd_i = 1; @(negedge clk_i); stat_rd_i = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 cfg", 32'(cfg_o), 0);
    chk("R1 level", 32'(level_o), 0);
    chk("R1 empty", 32'(empty_o), 1);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 start", 32'(start_o), 0);
    chk("R1 flags", {30'd0, ovf_o, udf_o}, 0);

    // R10 pop on empty with nothing armed
    raw_pop(0);
    chk("R10 idle pop", 32'(udf_o), 0);

    // R2 protected write ignored, then accepted
    cfg_wr(2'b11, 1);
    chk("R2 protected", 32'(cfg_o), 0);
    cfg_wr(2'b10, 0);
    chk("R2 write", 32'(cfg_o), 2);
    cfg_wr(2'b00, 0);

    // R6 short block len 3
    cmd(3);
    push_n(2); @(negedge clk_i);
    chk("R6 below len", 32'(start_o), 0);
    push_n(1);
    chk("R8 registered delay", 32'(start_o), 0);
    @(negedge clk_i);
    chk("R6 whole block", 32'(start_o), 1);
    pop_n(2);
    chk("R8 held", 32'(start_o), 1);
    pop_n(1);
    chk("R8 drop on last", 32'(start_o), 0);
    chk("R3 empty", 32'(empty_o), 1);

    // R5 quarter band: len 8, threshold 4
    cmd(8);
    push_n(3); @(negedge clk_i);
    chk("R5 below quarter", 32'(start_o), 0);
    push_n(1); @(negedge clk_i);
    chk("R5 quarter", 32'(start_o), 1);
    push_n(4); pop_n(8);
    chk("R8 quarter done", 32'(start_o), 0);

    // R4 half band: len 12 on boundary, threshold 8
    cmd(12);
    push_n(7); @(negedge clk_i);
    chk("R4 below half", 32'(start_o), 0);
    push_n(1); @(negedge clk_i);
    chk("R4 half", 32'(start_o), 1);
    begin : pushpop
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      chk("R3 order pushpop", 32'(pop_data_o), 32'(e));
      seed = seed + 16'h0101; exp_q.push_back(seed);
      push_i = 1; push_data_i = seed; pop_i = 1;
      @(negedge clk_i); push_i = 0; pop_i = 0;
    end
    chk("R3 same level", 32'(level_o), 8);
    push_n(3); pop_n(11);
    chk("R8 half done", 32'(start_o), 0);

    // R7 immediate start
    cfg_wr(2'b01, 0);
    cmd(12);
    push_n(1); @(negedge clk_i);
    chk("R7 immediate", 32'(start_o), 1);
    push_n(11); pop_n(12);
    chk("R7 done", 32'(start_o), 0);
    cfg_wr(2'b00, 0);

    // R9 overflow, discarded word
    push_n(16);
    chk("R3 full", 32'(full_o), 1);
    push_w();
    chk("R9 ovf", 32'(ovf_o), 1);
    chk("R9 level kept", 32'(level_o), 16);
    pop_n(16);
    chk("R9 discarded", 32'(empty_o), 1);

    // R11 command-clear policy
    stat_rd();
    chk("R11 stat no clear", 32'(ovf_o), 1);
    cmd(3);
    chk("R11 cmd clears", 32'(ovf_o), 0);

    // R10 underflow while armed
    raw_pop(0);
    chk("R10 udf", 32'(udf_o), 1);

    // R11 status-clear policy
    cfg_wr(2'b10, 0);
    cmd(3);
    chk("R11 cmd no clear", 32'(udf_o), 1);
    stat_rd();
    chk("R11 stat clears", 32'(udf_o), 0);

    // R12 event beats clear
    raw_pop(1);
    chk("R12 set wins", 32'(udf_o), 1);
    stat_rd();
    chk("R12 later clear", 32'(udf_o), 0);

    done = 1;
    finish_run();
  end
endmodule